// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by reading a two-level page map held in main memory. The root table stays resident at a physical base supplied on a configuration input. Bits 31:22 of the virtual address select a word in that root table. The entry read there names the physical page of a second-level table. Bits 21:12 then select a word in that second-level page, and the entry read there names the physical page of the data. Bits 11:0 pass straight through as the byte offset.

A client raises a walk request while the walker reports itself ready. The walker then issues up to two word reads on a simple memory port, one read at a time. It holds each read until the memory returns valid data. It ends every walk with a one-cycle completion pulse, together with either the physical address or a fault code that names the lookup whose entry was not resident. Fault service, translation caching and backing-store transfers belong to other blocks.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset the walker is ready (`walk_ready`=1), does not request memory (`mem_req`=0) and does not signal completion (`walk_done`=0).
- R2: A walk request is taken only while `walk_ready` is 1. A request raised during a walk has no effect on that walk's reads or result.
- R3: The first read is at address `root_base + 4*va[31:22]`. `mem_req` and `mem_addr` stay unchanged until the cycle in which `mem_valid` is 1.
- R4: If bit 31 (resident) of the root-table entry is 0, the walk ends with `walk_fault`=1 and `fault_level`=2'd1, and no second read is issued.
- R5: If the root-table entry is resident, the second read is at address `{E1[17:0], va[21:12], 2'b00}`, where E1 is that entry.
- R6: If bit 31 of the second-level entry is 0, the walk ends with `walk_fault`=1 and `fault_level`=2'd2.
- R7: On success, `pa` = `{E2[17:0], va[11:0]}` with `walk_fault`=0 and `fault_level`=2'd0, where E2 is the second-level entry. Entry bits 30:18 have no effect.
- R8: `walk_done` is high for exactly one cycle, in the cycle after the final read is accepted, and the walker is ready again in the following cycle.
- R9: `mem_valid` asserted while `mem_req` is 0 is ignored. It neither starts nor advances a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 30 | Physical byte address of the root table |
| walk_req | input | 1 | Start a walk (taken only when ready) |
| walk_va | input | 32 | Virtual address to translate |
| walk_ready | output | 1 | Walker idle and able to take a request |
| mem_req | output | 1 | Word read request, held until valid |
| mem_addr | output | 30 | Byte address of the word read |
| mem_valid | input | 1 | Read data valid; completes the pending read |
| mem_rdata | input | 32 | Read data (a page map entry) |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Walk ended on a non-resident entry |
| fault_level | output | 2 | 1 = root entry absent, 2 = second-level entry absent, 0 = success |
| pa | output | 30 | Translated physical address (valid when done without fault) |

## Verification
Walks run against a sparse memory model with read latencies from zero to four cycles. This shows that requests are held and that back-to-back reads work when data returns in the same cycle. The address patterns cover the lowest and highest index values and a non-zero root base. They also cover entries with junk in the bits between the page number and the resident bit, which separates correct field extraction from simple pass-through. Walks that are absent at the first or the second level are distinguished by the fault code and by whether a second read occurs. Stray valid pulses in idle and requests made during a busy walk must leave the cycle trace identical to that of the reference model.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_L1   = 2'd1,
    WK_L2   = 2'd2,
    WK_RESP = 2'd3
  } wk_state_e;
endpackage

// File: rtl/pw_pte_decode.sv
// Splits a page map entry into its resident flag and page number.
module pw_pte_decode #(
  parameter int PTE_W   = 32,
  parameter int PPN_W   = 18,
  parameter int RES_BIT = 31
) (
  input  logic [PTE_W-1:0] pte,
  output logic             resident,
  output logic [PPN_W-1:0] ppn
);
  assign resident = pte[RES_BIT];
  assign ppn      = pte[PPN_W-1:0];
endmodule

// File: rtl/pw_addr_gen.sv
// Forms the byte address of the entry read for the current level.
module pw_addr_gen #(
  parameter int PA_W  = 30,
  parameter int IDX_W = 10,
  parameter int PPN_W = 18,
  parameter int ENT_B = 2
) (
  input  logic             second,
  input  logic [PA_W-1:0]  root_base,
  input  logic [IDX_W-1:0] idx_top,
  input  logic [IDX_W-1:0] idx_mid,
  input  logic [PPN_W-1:0] tbl_ppn,
  output logic [PA_W-1:0]  addr
);
  localparam int OFF_W = IDX_W + ENT_B;
  logic [PA_W-1:0] top_ofs;
  logic [PA_W-1:0] top_addr;
  logic [PA_W-1:0] mid_addr;

  assign top_ofs  = {{(PA_W-OFF_W){1'b0}}, idx_top, {ENT_B{1'b0}}};
  assign top_addr = root_base + top_ofs;
  assign mid_addr = {tbl_ppn, idx_mid, {ENT_B{1'b0}}};
  assign addr     = second ? mid_addr : top_addr;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 10,
  parameter int PTE_W   = 32,
  parameter int RES_BIT = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PA_W-1:0]  root_base,
  input  logic             walk_req,
  input  logic [VA_W-1:0]  walk_va,
  output logic             walk_ready,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_valid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             walk_done,
  output logic             walk_fault,
  output logic [1:0]       fault_level,
  output logic [PA_W-1:0]  pa
);
  import pw_pkg::*;

  localparam int PPN_W = PA_W - OFS_W;
  localparam int ENT_B = OFS_W - IDX_W;
  localparam int TOP_L = VA_W - IDX_W;
  localparam int MID_L = OFS_W;

  wk_state_e         state;
  logic [VA_W-1:0]   va_q;
  logic [PPN_W-1:0]  tbl_ppn_q;
  logic [PA_W-1:0]   pa_q;
  logic              fault_q;
  logic [1:0]        lvl_q;
  logic              ent_res;
  logic [PPN_W-1:0]  ent_ppn;

  pw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W), .RES_BIT(RES_BIT)) u_dec (
    .pte(mem_rdata), .resident(ent_res), .ppn(ent_ppn)
  );

  pw_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W), .PPN_W(PPN_W), .ENT_B(ENT_B)) u_agen (
    .second(state == WK_L2), .root_base(root_base),
    .idx_top(va_q[VA_W-1:TOP_L]), .idx_mid(va_q[TOP_L-1:MID_L]),
    .tbl_ppn(tbl_ppn_q), .addr(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WK_IDLE;
      va_q      <= '0;
      tbl_ppn_q <= '0;
      pa_q      <= '0;
      fault_q   <= 1'b0;
      lvl_q     <= 2'd0;
    end else begin
      unique case (state)
        WK_IDLE: if (walk_req) begin
          va_q  <= walk_va;
          state <= WK_L1;
        end
        WK_L1: if (mem_valid) begin
          if (!ent_res) begin
            fault_q <= 1'b1;
            lvl_q   <= 2'd1;
            state   <= WK_RESP;
          end else begin
            tbl_ppn_q <= ent_ppn;
            state     <= WK_L2;
          end
        end
        WK_L2: if (mem_valid) begin
          if (!ent_res) begin
            fault_q <= 1'b1;
            lvl_q   <= 2'd2;
          end else begin
            fault_q <= 1'b0;
            lvl_q   <= 2'd0;
            pa_q    <= {ent_ppn, va_q[OFS_W-1:0]};
          end
          state <= WK_RESP;
        end
        WK_RESP: state <= WK_IDLE;
        default: state <= WK_IDLE;
      endcase
    end
  end

  assign walk_ready  = (state == WK_IDLE);
  assign mem_req     = (state == WK_L1) || (state == WK_L2);
  assign walk_done   = (state == WK_RESP);
  assign walk_fault  = fault_q;
  assign fault_level = lvl_q;
  assign pa          = pa_q;

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    (walk_ready && walk_req) |=> !walk_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> (!walk_done && walk_ready));

  assert_fault_code_R6: assert property (@(posedge clk) disable iff (rst)
    (walk_done && walk_fault) |-> (fault_level == 2'd1 || fault_level == 2'd2));

  assert_ok_code_R7: assert property (@(posedge clk) disable iff (rst)
    (walk_done && !walk_fault) |-> (fault_level == 2'd0));

  assert_stray_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (walk_ready && !walk_req && mem_valid) |=> walk_ready);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic [29:0] root_base;
  logic        walk_req;
  logic [31:0] walk_va;
  logic        walk_ready, mem_req, walk_done, walk_fault;
  logic [29:0] mem_addr, pa;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  fault_level;

  always #4 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst(rst), .root_base(root_base), .walk_req(walk_req), .walk_va(walk_va),
    .walk_ready(walk_ready), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .walk_done(walk_done), .walk_fault(walk_fault),
    .fault_level(fault_level), .pa(pa)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // sparse memory and responder
  logic [31:0] pmem [int unsigned];
  int lat = 0;
  int wcnt = 0;
  bit stray = 0;

  function automatic logic [31:0] rd(input logic [29:0] a);
    int unsigned k = {2'b00, a};
    return pmem.exists(k) ? pmem[k] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_valid <= 1'b1;
        mem_rdata <= rd(mem_addr);
        wcnt      <= 0;
      end else begin
        mem_valid <= 1'b0;
        wcnt      <= wcnt + 1;
      end
    end else begin
      mem_valid <= stray;
      mem_rdata <= 32'hFFFF_FFFF;
      wcnt      <= 0;
    end
  end

  // behavioural reference: phase 0 idle, 1 first read, 2 second read, 3 result
  int          m_ph = 0;
  logic [31:0] m_va = '0;
  logic [17:0] m_tp = '0;
  logic [29:0] m_pa = '0;
  bit          m_f = 0;
  int          m_lv = 0;

  always @(posedge clk) begin
    if (rst) m_ph = 0;
    else begin
      case (m_ph)
        0: if (walk_req) begin m_va = walk_va; m_ph = 1; end
        1: if (mem_valid) begin
             if (!mem_rdata[31]) begin m_f = 1; m_lv = 1; m_ph = 3; end
             else begin m_tp = mem_rdata[17:0]; m_ph = 2; end
           end
        2: if (mem_valid) begin
             if (!mem_rdata[31]) begin m_f = 1; m_lv = 2; end
             else begin m_f = 0; m_lv = 0; m_pa = {mem_rdata[17:0], m_va[11:0]}; end
             m_ph = 3;
           end
        default: m_ph = 0;
      endcase
    end
  end

  bit          got_done = 0;
  bit          r_fault;
  logic [1:0]  r_lvl;
  logic [29:0] r_pa;

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      logic [29:0] e_addr;
      e_addr = (m_ph == 2) ? {m_tp, m_va[21:12], 2'b00}
                           : root_base + {18'd0, m_va[31:22], 2'b00};
      chk(walk_ready == (m_ph == 0), stray ? "R9" : "R2", "walk_ready", 32'(walk_ready), 32'(m_ph == 0));
      chk(mem_req == (m_ph == 1 || m_ph == 2), (m_ph == 3) ? "R4" : "R3", "mem_req",
          32'(mem_req), 32'(m_ph == 1 || m_ph == 2));
      if (m_ph == 1) chk(mem_addr == e_addr, "R3", "first read address", 32'(mem_addr), 32'(e_addr));
      if (m_ph == 2) chk(mem_addr == e_addr, "R5", "second read address", 32'(mem_addr), 32'(e_addr));
      chk(walk_done == (m_ph == 3), "R8", "walk_done", 32'(walk_done), 32'(m_ph == 3));
      if (m_ph == 3 && walk_done) begin
        chk(walk_fault == m_f, m_f ? "R4" : "R7", "walk_fault", 32'(walk_fault), 32'(m_f));
        chk(fault_level == 2'(m_lv), (m_lv == 2) ? "R6" : "R4", "fault_level",
            32'(fault_level), 32'(m_lv));
        if (!m_f) chk(pa == m_pa, "R7", "pa", 32'(pa), 32'(m_pa));
      end
      if (walk_done) begin
        got_done = 1; r_fault = walk_fault; r_lvl = fault_level; r_pa = pa;
      end
    end
  end

  task automatic place(input logic [29:0] rb, input logic [31:0] va, input bit res1, input bit res2,
                       input logic [17:0] p1, input logic [17:0] p2, input logic [12:0] junk);
    logic [29:0] a1, a2;
    pmem.delete();
    a1 = rb + {18'd0, va[31:22], 2'b00};
    a2 = {p1, va[21:12], 2'b00};
    pmem[{2'b00, a1}] = {res1, junk, p1};
    pmem[{2'b00, a2}] = {res2, junk, p2};
  endtask

  task automatic walk(input logic [31:0] va, input bit poke_busy);
    @(negedge clk);
    while (!walk_ready) @(negedge clk);
    got_done = 0;
    walk_req = 1'b1;
    walk_va  = va;
    @(negedge clk);
    walk_req = 1'b0;
    if (poke_busy) begin
      walk_req = 1'b1;
      walk_va  = ~va;
    end
    while (!got_done) @(negedge clk);
    walk_req = 1'b0;
  endtask

  task automatic expect_res(input bit f, input logic [1:0] l, input logic [29:0] p, input string tag);
    chk(r_fault == f, tag, "result fault", 32'(r_fault), 32'(f));
    chk(r_lvl == l, tag, "result level", 32'(r_lvl), 32'(l));
    if (!f) chk(r_pa == p, tag, "result pa", 32'(r_pa), 32'(p));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; walk_req = 1'b0; walk_va = '0; root_base = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(walk_ready == 1'b1, "R1", "ready after reset", 32'(walk_ready), 32'd1);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
    chk(walk_done == 1'b0, "R1", "done after reset", 32'(walk_done), 32'd0);

    // R7 R3 R5: zero root base, zero latency
    lat = 0; root_base = 30'h0;
    place(root_base, 32'h0040_3ABC, 1, 1, 18'h00010, 18'h20001, 13'h0);
    walk(32'h0040_3ABC, 0);
    expect_res(0, 2'd0, {18'h20001, 12'hABC}, "R7");

    // R3 R5: highest indices, non-zero root, read latency 3
    lat = 3; root_base = 30'h0001_5000;
    place(root_base, 32'hFFFF_F123, 1, 1, 18'h3FFFF, 18'h12345, 13'h0);
    walk(32'hFFFF_F123, 0);
    expect_res(0, 2'd0, {18'h12345, 12'h123}, "R5");

    // R4: root entry not resident
    lat = 1;
    place(root_base, 32'h1234_5678, 0, 1, 18'h00111, 18'h00222, 13'h0);
    walk(32'h1234_5678, 0);
    expect_res(1, 2'd1, '0, "R4");

    // R6: second-level entry not resident
    lat = 2;
    place(root_base, 32'h8765_4321, 1, 0, 18'h00333, 18'h00444, 13'h0);
    walk(32'h8765_4321, 0);
    expect_res(1, 2'd2, '0, "R6");

    // R2: request held high during a busy walk
    lat = 4;
    place(root_base, 32'h00C0_1FFF, 1, 1, 18'h00055, 18'h0ABCD, 13'h0);
    walk(32'h00C0_1FFF, 1);
    expect_res(0, 2'd0, {18'h0ABCD, 12'hFFF}, "R2");
    @(negedge clk);
    chk(walk_ready == 1'b1, "R2", "ready after busy walk", 32'(walk_ready), 32'd1);

    // R9: stray valid pulses while idle and around a walk
    lat = 0; stray = 1;
    repeat (5) @(negedge clk);
    chk(walk_ready == 1'b1 && walk_done == 1'b0, "R9", "idle under stray valid",
        32'({walk_ready, walk_done}), 32'b10);
    place(root_base, 32'h0280_2010, 1, 1, 18'h00777, 18'h00888, 13'h0);
    walk(32'h0280_2010, 0);
    expect_res(0, 2'd0, {18'h00888, 12'h010}, "R9");
    repeat (3) @(negedge clk);
    stray = 0;

    // R7: junk in bits between page number and resident flag
    lat = 1;
    place(root_base, 32'h3FC0_0AAA, 1, 1, 18'h01234, 18'h2FEDC, 13'h1FFF);
    walk(32'h3FC0_0AAA, 0);
    expect_res(0, 2'd0, {18'h2FEDC, 12'hAAA}, "R7");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule